// File: doc/BRIEF.md
# Temperature-Compensated Gate Bias Controller

This block keeps the gate bias codes of two power transistors correct as their temperatures move. Each channel receives a 12-bit temperature code. On every update strobe the block compares each channel's code with the one it saw at its last update. Only a channel whose code has changed reads its own 64-entry, 16-bit temperature-to-gate-voltage table. That entry is multiplied by the channel's calibration slope and rounded, then the channel's signed calibration offset is added. The saturated 18-bit result is split into an 8-bit coarse DAC code and a 10-bit fine DAC code.

The block comes out of reset in shutdown with all DAC codes at zero. It starts working only when the power-on input makes a low-to-high transition. A fast clamp input forces every DAC output to zero combinationally. The clamp does not pass through any register or the host port. A simple synchronous write / combinational read port gives the host access to a message word, the calibration registers and both tables.

Top module: `gate_bias_ctrl`

## Requirements
- R1: During and after reset all coarse and fine outputs are zero, and the block is in shutdown. After reset the message word and the tables read 0, slopes read 0x4000 (1.0) and offsets read 0.
- R2: The block leaves shutdown only after sampling `power_on` low in one cycle and high in the next. A `power_on` held high through reset does not start it. Once it is running, outputs follow the result of the next strobe.
- R3: In shutdown an update strobe leaves all outputs at zero.
- R4: The first strobe after leaving shutdown always updates both channels, whatever temperature code is present.
- R5: On a strobe where a channel's temperature code differs from the code at its last update, the channel's new 18-bit code is computed from its own table entry at index temp[11:6]. The code is clamp(floor((entry*slope + 8192)/16384) + offset, 0, 262143). The slope is unsigned Q2.14 and the offset is 16-bit two's complement.
- R6: A strobe with an unchanged temperature code leaves that channel's outputs unchanged, even if its table entry or calibration was rewritten since. Outputs also hold when there is no strobe.
- R7: Results below zero give code 0. Results above 262143 give code 262143 (coarse 0xFF, fine 0x3FF).
- R8: The coarse output is code[17:10] and the fine output is code[9:0]. Both change together, in the clock cycle after the edge that samples the strobe.
- R9: While `fast_clamp` is high all four DAC outputs are zero with no clock edge needed. When it falls, the held codes reappear unchanged.
- R10: Register map. 0x00 is the message word. 0x10 and 0x11 are channel A slope and offset. 0x12 and 0x13 are channel B slope and offset. 0x80+i is table A entry i and 0xC0+i is table B entry i. Any other address reads 0, and a write to it has no effect.
- R11: Channels are independent: channel A uses only table A, its own slope and offset and `temp_a`, and channel B likewise.
- R12: `power_on` low while running returns the block to shutdown. Outputs are zero two cycles after it is sampled low, and the next release behaves as in R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Update strobe |
| power_on | input | 1 | Shutdown release; rising edge starts operation, low forces shutdown |
| fast_clamp | input | 1 | Forces all DAC outputs to zero combinationally |
| temp_a | input | 12 | Channel A temperature code |
| temp_b | input | 12 | Channel B temperature code |
| host_we | input | 1 | Host write enable |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| coarse_a | output | 8 | Channel A coarse DAC code |
| fine_a | output | 10 | Channel A fine DAC code |
| coarse_b | output | 8 | Channel B coarse DAC code |
| fine_b | output | 10 | Channel B fine DAC code |

## Verification
The bench goes after repeated temperature codes with a rewritten table or slope between strobes. A design that updated on every strobe would show the new entry there. It drives offsets and slopes to their extremes, where a missing clamp would wrap the code to a small or huge value. It also checks that a `power_on` held high through reset does not start the block, and that the first strobe after a release updates even with an old temperature code. The fast clamp is checked between clock edges, and must then give back the held codes unchanged.

// File: rtl/gb_pkg.sv
package gb_pkg;
    localparam int NCH       = 2;
    localparam int TEMP_W    = 12;
    localparam int IDX_W     = 6;
    localparam int TAB_N     = 1 << IDX_W;
    localparam int ENTRY_W   = 16;
    localparam int COARSE_W  = 8;
    localparam int FINE_W    = 10;
    localparam int CODE_W    = COARSE_W + FINE_W;
    localparam int FRAC_W    = 14;
    localparam int ADDR_W    = 8;
    localparam int PROD_W    = 2 * ENTRY_W;
    localparam int SUM_W     = CODE_W + 3;
    localparam logic [ENTRY_W-1:0] SLOPE_ONE = ENTRY_W'(1 << FRAC_W);
    localparam logic [ADDR_W-1:0]  A_MSG     = 8'h00;
    localparam logic [ADDR_W-1:0]  A_CAL     = 8'h10;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [ENTRY_W-1:0] word_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef enum logic {ST_SHUT, ST_RUN} pwr_state_e;

    function automatic code_t bias_correct(word_t entry, word_t slope, word_t offs);
        logic [PROD_W-1:0]       prod;
        logic [CODE_W:0]         rnd;
        logic signed [SUM_W-1:0] sum;
        prod = PROD_W'(entry) * PROD_W'(slope);
        rnd  = (CODE_W+1)'((prod + PROD_W'(1 << (FRAC_W-1))) >> FRAC_W);
        sum  = $signed({2'b00, rnd}) + $signed({{(SUM_W-ENTRY_W){offs[ENTRY_W-1]}}, offs});
        if (sum < 0)
            return '0;
        else if (sum > $signed(SUM_W'((1 << CODE_W) - 1)))
            return '1;
        else
            return sum[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/gb_seq.sv
module gb_seq
    import gb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic power_on,
    output logic run
);
    pwr_state_e st_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_SHUT;
            prev_q <= 1'b1;
        end else begin
            prev_q <= power_on;
            case (st_q)
                ST_SHUT: if (power_on && !prev_q) st_q <= ST_RUN;
                default: if (!power_on)           st_q <= ST_SHUT;
            endcase
        end
    end

    assign run = (st_q == ST_RUN);

    AST_STAY_SHUT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHUT && !power_on) |=> (st_q == ST_SHUT)); // R2
endmodule

// File: rtl/gb_regfile.sv
module gb_regfile
    import gb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  word_t                   wdata,
    output word_t                   rdata,
    input  idx_t  [NCH-1:0]         rd_idx,
    output word_t [NCH-1:0]         rd_entry,
    output word_t [NCH-1:0]         slope,
    output word_t [NCH-1:0]         offs
);
    word_t msg_q;
    word_t slope_q [NCH];
    word_t offs_q  [NCH];
    word_t tab_q   [NCH][TAB_N];

    logic              is_tab;
    logic              tab_ch;
    idx_t              tab_idx;
    logic              is_cal;
    logic              cal_ch;
    logic              cal_off;

    assign is_tab  = addr[ADDR_W-1];
    assign tab_ch  = addr[IDX_W];
    assign tab_idx = addr[IDX_W-1:0];
    assign is_cal  = (addr[ADDR_W-1:2] == A_CAL[ADDR_W-1:2]);
    assign cal_ch  = addr[1];
    assign cal_off = addr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
            for (int c = 0; c < NCH; c++) begin
                slope_q[c] <= SLOPE_ONE;
                offs_q[c]  <= '0;
                for (int i = 0; i < TAB_N; i++) tab_q[c][i] <= '0;
            end
        end else if (we) begin
            if (addr == A_MSG)
                msg_q <= wdata;
            else if (is_cal && !cal_off)
                slope_q[cal_ch] <= wdata;
            else if (is_cal)
                offs_q[cal_ch] <= wdata;
            else if (is_tab)
                tab_q[tab_ch][tab_idx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MSG)
            rdata = msg_q;
        else if (is_cal && !cal_off)
            rdata = slope_q[cal_ch];
        else if (is_cal)
            rdata = offs_q[cal_ch];
        else if (is_tab)
            rdata = tab_q[tab_ch][tab_idx];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_port
        assign rd_entry[c] = tab_q[c][rd_idx[c]];
        assign slope[c]    = slope_q[c];
        assign offs[c]     = offs_q[c];
    end
endmodule

// File: rtl/gb_channel.sv
module gb_channel
    import gb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [TEMP_W-1:0] temp,
    output idx_t              rd_idx,
    input  word_t             entry,
    input  word_t             slope,
    input  word_t             offs,
    output code_t             code
);
    logic              valid_q;
    logic [TEMP_W-1:0] last_q;
    code_t             code_q;
    logic              changed;

    assign rd_idx  = temp[TEMP_W-1 -: IDX_W];
    assign changed = !valid_q || (temp != last_q);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            valid_q <= 1'b0;
            last_q  <= '0;
            code_q  <= '0;
        end else if (tick && changed) begin
            valid_q <= 1'b1;
            last_q  <= temp;
            code_q  <= bias_correct(entry, slope, offs);
        end
    end

    assign code = code_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(code_q)); // R6
    AST_SAME_TEMP: assert property (@(posedge clk) disable iff (rst)
        (run && valid_q && tick && temp == last_q) |=> $stable(code_q)); // R6
    AST_SHUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (code_q == '0)); // R3
endmodule

// File: rtl/gate_bias_ctrl.sv
module gate_bias_ctrl
    import gb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                power_on,
    input  logic                fast_clamp,
    input  logic [TEMP_W-1:0]   temp_a,
    input  logic [TEMP_W-1:0]   temp_b,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [ENTRY_W-1:0]  host_wdata,
    output logic [ENTRY_W-1:0]  host_rdata,
    output logic [COARSE_W-1:0] coarse_a,
    output logic [FINE_W-1:0]   fine_a,
    output logic [COARSE_W-1:0] coarse_b,
    output logic [FINE_W-1:0]   fine_b
);
    logic                      run;
    logic [NCH-1:0][TEMP_W-1:0] temps;
    idx_t  [NCH-1:0]           rd_idx;
    word_t [NCH-1:0]           entry;
    word_t [NCH-1:0]           slope;
    word_t [NCH-1:0]           offs;
    code_t [NCH-1:0]           code;
    code_t [NCH-1:0]           code_out;

    assign temps[0] = temp_a;
    assign temps[1] = temp_b;

    gb_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .power_on (power_on),
        .run      (run)
    );

    gb_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (host_we),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .rdata    (host_rdata),
        .rd_idx   (rd_idx),
        .rd_entry (entry),
        .slope    (slope),
        .offs     (offs)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gb_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .tick   (tick),
            .temp   (temps[c]),
            .rd_idx (rd_idx[c]),
            .entry  (entry[c]),
            .slope  (slope[c]),
            .offs   (offs[c]),
            .code   (code[c])
        );
        assign code_out[c] = fast_clamp ? '0 : code[c];
    end

    assign coarse_a = code_out[0][CODE_W-1:FINE_W];
    assign fine_a   = code_out[0][FINE_W-1:0];
    assign coarse_b = code_out[1][CODE_W-1:FINE_W];
    assign fine_b   = code_out[1][FINE_W-1:0];

    AST_RELEASE_OUT: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |=> (code[0] == '0 && code[1] == '0)); // R12
endmodule

// File: tb/gate_bias_ctrl_bench.sv
module gate_bias_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, tick, power_on, fast_clamp, host_we;
    logic [11:0] temp_a, temp_b;
    logic [7:0]  host_addr;
    logic [15:0] host_wdata, host_rdata;
    logic [7:0]  coarse_a, coarse_b;
    logic [9:0]  fine_a, fine_b;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_tab [2][64];
    logic [15:0] m_slope [2];
    logic [15:0] m_offs [2];
    logic [11:0] m_last [2];
    bit          m_have [2];
    logic [17:0] m_code [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_bias_ctrl u_gate_bias_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .power_on(power_on), .fast_clamp(fast_clamp),
        .temp_a(temp_a), .temp_b(temp_b), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .coarse_a(coarse_a),
        .fine_a(fine_a), .coarse_b(coarse_b), .fine_b(fine_b)
    );

    function automatic logic [17:0] exp_code(logic [15:0] e, logic [15:0] s, logic [15:0] o);
        longint v;
        v = ((longint'(e) * longint'(s)) + 8192) / 16384;
        v = v + longint'($signed(o));
        if (v < 0) v = 0;
        if (v > 262143) v = 262143;
        return 18'(v);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_out(string req);
        chk(req, {14'd0, coarse_a, fine_a}, {14'd0, m_code[0]});
        chk(req, {14'd0, coarse_b, fine_b}, {14'd0, m_code[1]});
    endtask

    task automatic hwrite(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
        if (a >= 8'h80) m_tab[a[6]][a[5:0]] = d;
        else if (a == 8'h10 || a == 8'h12) m_slope[a[1]] = d;
        else if (a == 8'h11 || a == 8'h13) m_offs[a[1]] = d;
    endtask

    task automatic hread_chk(string req, logic [7:0] a, logic [15:0] expv);
        @(negedge clk);
        host_addr = a;
        #1 chk(req, {16'd0, host_rdata}, {16'd0, expv});
    endtask

    task automatic do_tick(logic [11:0] ta, logic [11:0] tb, bit running);
        logic [11:0] t [2];
        t[0] = ta; t[1] = tb;
        @(negedge clk);
        temp_a = ta; temp_b = tb; tick = 1;
        @(negedge clk);
        tick = 0;
        if (running)
            for (int c = 0; c < 2; c++)
                if (!m_have[c] || m_last[c] != t[c]) begin
                    m_have[c] = 1; m_last[c] = t[c];
                    m_code[c] = exp_code(m_tab[c][t[c][11:6]], m_slope[c], m_offs[c]);
                end
    endtask

    task automatic go_shut();
        @(negedge clk); power_on = 0;
        @(negedge clk); @(negedge clk);
        m_have[0] = 0; m_have[1] = 0; m_code[0] = 0; m_code[1] = 0;
    endtask

    task automatic release_on();
        @(negedge clk); power_on = 1;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7531));
        rst = 1; tick = 0; power_on = 1; fast_clamp = 0; host_we = 0;
        host_addr = 0; host_wdata = 0; temp_a = 0; temp_b = 0;
        for (int c = 0; c < 2; c++) begin
            m_slope[c] = 16'h4000; m_offs[c] = 0; m_have[c] = 0; m_code[c] = 0; m_last[c] = 0;
            for (int i = 0; i < 64; i++) m_tab[c][i] = 0;
        end
        repeat (3) @(negedge clk);
        chk_out("R1 outputs in reset");
        rst = 0;
        chk_out("R1 outputs after reset");
        hread_chk("R1 slope A reset", 8'h10, 16'h4000);
        hread_chk("R1 offset B reset", 8'h13, 16'h0000);
        hread_chk("R1 table reset", 8'hC5, 16'h0000);

        // register map
        hwrite(8'h00, 16'hBEEF);
        hread_chk("R10 message word", 8'h00, 16'hBEEF);
        hwrite(8'h20, 16'h1234);
        hread_chk("R10 unmapped reads zero", 8'h20, 16'h0000);
        hread_chk("R10 unmapped write no effect", 8'h00, 16'hBEEF);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 64; i++)
                hwrite(8'h80 + 8'(c*64 + i), 16'($urandom));
        hread_chk("R10 table A entry", 8'h87, m_tab[0][7]);
        hread_chk("R10 table B entry", 8'hFE, m_tab[1][62]);
        hwrite(8'h10, 16'h5000);
        hwrite(8'h11, 16'hFF00);
        hwrite(8'h12, 16'h3000);
        hwrite(8'h13, 16'h0123);
        hread_chk("R10 offset A", 8'h11, 16'hFF00);

        // shutdown held high through reset: no start
        do_tick(12'h123, 12'h456, 0);
        chk_out("R2 no start without rising edge");
        chk_out("R3 tick in shutdown");
        power_on = 0;
        release_on();
        chk_out("R2 running holds until tick");
        do_tick(12'h123, 12'h456, 1);
        chk_out("R5 first update after release");

        // same temp with rewritten table/cal
        hwrite(8'h80 + 8'(12'h123 >> 6), 16'hAAAA);
        hwrite(8'h10, 16'h7000);
        do_tick(12'h123, 12'h456, 1);
        chk_out("R6 same temp ignores rewrite");
        do_tick(12'h13F, 12'h7A0, 1);
        chk_out("R11 A low bits change uses new entry");

        // clamp
        @(negedge clk); fast_clamp = 1;
        #1 chk("R9 clamp A", {14'd0, coarse_a, fine_a}, 0);
        chk("R9 clamp B", {14'd0, coarse_b, fine_b}, 0);
        @(negedge clk); fast_clamp = 0;
        #1 chk_out("R9 release restores");

        // saturation high
        hwrite(8'h80 + 8'd10, 16'hFFFF);
        hwrite(8'h10, 16'hFFFF);
        hwrite(8'h11, 16'h7FFF);
        do_tick(12'd10 << 6, 12'h7A0, 1);
        chk("R7 saturate high", {14'd0, coarse_a, fine_a}, 32'h3FFFF);
        chk("R8 coarse field", {24'd0, coarse_a}, 32'hFF);
        // saturation low
        hwrite(8'hC0 + 8'd3, 16'h0100);
        hwrite(8'h13, 16'h8000);
        do_tick(12'd10 << 6, 12'd3 << 6, 1);
        chk("R7 saturate low", {14'd0, coarse_b, fine_b}, 0);
        chk_out("R11 independent channels");

        // shutdown while running, then release with old temps
        go_shut();
        chk_out("R12 outputs zero after power_on low");
        hwrite(8'h11, 16'h0040);
        hwrite(8'h13, 16'h0777);
        release_on();
        do_tick(12'd10 << 6, 12'd3 << 6, 1);
        chk_out("R4 first tick after release updates");

        // random run
        for (int n = 0; n < 300; n++) begin
            logic [11:0] ta, tb;
            ta = ($urandom % 4 == 0) ? m_last[0] : 12'($urandom);
            tb = ($urandom % 4 == 0) ? m_last[1] : 12'($urandom);
            if ($urandom % 8 == 0) hwrite(8'h80 + 8'($urandom % 128), 16'($urandom));
            if ($urandom % 16 == 0) hwrite(8'h10 + 8'($urandom % 4), 16'($urandom));
            do_tick(ta, tb, 1);
            chk_out("R5 random update");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule